// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block runs the receive side of a packet interface. Software builds a ring of four-word descriptors in a word-addressed memory. The engine walks that ring one frame at a time. The words of each descriptor, in address order, are status, control/size, buffer address and next address. When a frame is announced, the engine reads the status word at its ring pointer. Bit 31 of that word says whether the hardware owns the descriptor. If it does, the engine reads the control word and writes back a completion status that returns the descriptor to software. It then steps its pointer by four words, or jumps back to the ring base.

Payload bytes are not moved by this block. A frame always ends in the descriptor it lands in, and the next-address word is never used. Software loads the ring base address while the engine is stopped, and a level control input starts and stops the receive process. All memory traffic uses a simple request/acknowledge port.

Top module: `rxd_ring_engine`

## Requirements
- R1: After reset, `proc_state` is 0, and `mem_req`, `frm_ready` and `buf_unavail` are all low.
- R2: A `base_we` pulse while `proc_state` is 0 sets both the ring base and the ring pointer to `base_addr`. A `base_we` pulse at any other time has no effect: the next access still goes to the old pointer.
- R3: While `run_en` is low, the engine settles to `proc_state` 0, issues no memory request and never raises `frm_ready`, even with `frm_valid` held high. The stop takes effect only between frames. After a restart, the engine continues at its current pointer.
- R4: For each announced frame, the first access is a read of the status word at the pointer. Bit 31 of that word set means the hardware owns the descriptor.
- R5: If bit 31 is clear, the frame is dropped. `frm_ready` and `buf_unavail` are both high in the same cycle, nothing is written, and the pointer stays where it is.
- R6: For an owned descriptor, the engine reads the control word at pointer+1 and then writes the status word at pointer. The written word holds the frame length, including its 4-byte check sequence, in bits 31:16. Bit 15 holds the error flag and bit 8 (last descriptor) is 1. Every other bit, including the ownership bit 31, is 0.
- R7: The buffer size is control bits 10:0. A frame longer than this is reported with its length cut to the buffer size and with bit 15 set. A frame whose length equals the buffer size is not cut.
- R8: After a write-back, the pointer advances by 4. If control bit 25 (end of ring) was set, the pointer goes back to the ring base instead.
- R9: A memory request holds its address, direction and write data stable until `mem_ack`. Each accepted frame costs exactly two reads and one write. Each dropped frame costs one read. The buffer-address and next-address words are never accessed.
- R10: `frm_ready` is a single-cycle pulse, and the engine finishes exactly one frame per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Receive process enable (level) |
| base_we | input | 1 | Load ring base (honoured only when stopped) |
| base_addr | input | ADDR_W | Ring base word address |
| frm_valid | input | 1 | A frame is waiting to be completed |
| frm_len | input | 16 | Frame length in bytes, including the check sequence |
| frm_err | input | 1 | Frame arrived with an error |
| frm_ready | output | 1 | Frame completed or dropped this cycle |
| buf_unavail | output | 1 | Frame dropped because the descriptor is owned by software |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completes this cycle |
| proc_state | output | 3 | Engine state; 0 means stopped |

## Verification
The assertions assume three things about the inputs. The frame source holds `frm_valid`, `frm_len` and `frm_err` steady until `frm_ready`. The memory raises `mem_ack` only while `mem_req` is high, for one cycle per access. Software sizes buffers so that no length reaches bit 15 of the length field. The bench drives its frame task and memory model to match all three. It acknowledges after zero to two wait cycles and then drops `mem_ack` for a cycle. Its buffer sizes stay within 11 bits, and it hands ownership back only while no frame is in flight.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int WORD_W     = 32;
    localparam int LEN_W      = 16;
    localparam int DESC_WORDS = 4;
    localparam int OWN_BIT    = 31;
    localparam int EOR_BIT    = 25;
    localparam int ERR_BIT    = 15;
    localparam int LAST_BIT   = 8;
    localparam int LEN_LSB    = 16;

    typedef enum logic [2:0] {
        ST_STOP  = 3'd0,
        ST_OWN   = 3'd1,
        ST_CTRL  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_WB    = 3'd4,
        ST_CLOSE = 3'd5,
        ST_DROP  = 3'd6
    } eng_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             err;
    } frame_info_t;

    function automatic logic [WORD_W-1:0] pack_status(input logic [LEN_W-1:0] len,
                                                      input logic err);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LEN_LSB +: LEN_W] = len;
        w[ERR_BIT]          = err;
        w[LAST_BIT]         = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/rxd_status_fmt.sv
module rxd_status_fmt
    import rxd_pkg::*;
#(
    parameter int SIZE_W = 11
) (
    input  logic [WORD_W-1:0] ctrl_word,
    input  frame_info_t       frame,
    output logic [WORD_W-1:0] status_word
);
    logic [LEN_W-1:0] buf_size;
    logic [LEN_W-1:0] len_out;
    logic             too_long;
    logic             ctrl_unused;

    assign ctrl_unused = ^ctrl_word;

    always_comb begin
        buf_size    = LEN_W'(ctrl_word[SIZE_W-1:0]);
        too_long    = frame.len > buf_size;
        len_out     = too_long ? buf_size : frame.len;
        status_word = pack_status(len_out, frame.err | too_long);
    end

endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    input  logic              eor,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] base
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_WORDS);

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            ptr  <= '0;
        end else if (load) begin
            base <= load_addr;
            ptr  <= load_addr;
        end else if (advance) begin
            ptr <= eor ? base : ptr + STEP;
        end
    end

    // R8
    ring_step_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && !eor) |=> (ptr == $past(ptr) + STEP));

    // R8
    ring_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && eor) |=> (ptr == base));

endmodule

// File: rtl/rxd_seq.sv
module rxd_seq
    import rxd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic       frm_valid,
    input  logic       mem_ack,
    input  logic       own_flag,
    output eng_state_e state,
    output logic       mem_req,
    output logic       mem_we,
    output logic       word_sel,
    output logic       capture,
    output logic       ctrl_load,
    output logic       advance,
    output logic       frm_ready,
    output logic       buf_unavail
);
    eng_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_STOP;
        else     state <= nxt;
    end

    always_comb begin
        nxt         = state;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        word_sel    = 1'b0;
        capture     = 1'b0;
        ctrl_load   = 1'b0;
        advance     = 1'b0;
        frm_ready   = 1'b0;
        buf_unavail = 1'b0;
        case (state)
            ST_STOP: if (run_en) nxt = ST_WAIT;
            ST_WAIT: begin
                if (!run_en) nxt = ST_STOP;
                else if (frm_valid) begin
                    capture = 1'b1;
                    nxt     = ST_OWN;
                end
            end
            ST_OWN: begin
                mem_req = 1'b1;
                if (mem_ack) nxt = own_flag ? ST_CTRL : ST_DROP;
            end
            ST_CTRL: begin
                mem_req  = 1'b1;
                word_sel = 1'b1;
                if (mem_ack) begin
                    ctrl_load = 1'b1;
                    nxt       = ST_WB;
                end
            end
            ST_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    advance = 1'b1;
                    nxt     = ST_CLOSE;
                end
            end
            ST_CLOSE: begin
                frm_ready = 1'b1;
                nxt       = ST_WAIT;
            end
            ST_DROP: begin
                frm_ready   = 1'b1;
                buf_unavail = 1'b1;
                nxt         = ST_WAIT;
            end
            default: nxt = ST_STOP;
        endcase
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(word_sel)));

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frm_ready |=> !frm_ready);

    // R5
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        buf_unavail |-> (frm_ready && $past(mem_ack) && !$past(mem_we)));

endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_err,
    output logic              frm_ready,
    output logic              buf_unavail,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [2:0]        proc_state
);
    eng_state_e        state;
    logic              word_sel, capture, ctrl_load, advance, base_load;
    logic [ADDR_W-1:0] ptr, base;
    logic [WORD_W-1:0] ctrl_q;
    frame_info_t       finfo;

    rxd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .frm_valid  (frm_valid),
        .mem_ack    (mem_ack),
        .own_flag   (mem_rdata[OWN_BIT]),
        .state      (state),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .word_sel   (word_sel),
        .capture    (capture),
        .ctrl_load  (ctrl_load),
        .advance    (advance),
        .frm_ready  (frm_ready),
        .buf_unavail(buf_unavail)
    );

    assign base_load = base_we && (state == ST_STOP);

    rxd_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (base_load),
        .load_addr(base_addr),
        .advance  (advance),
        .eor      (ctrl_q[EOR_BIT]),
        .ptr      (ptr),
        .base     (base)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            finfo  <= '0;
            ctrl_q <= '0;
        end else begin
            if (capture)   finfo  <= '{len: frm_len, err: frm_err};
            if (ctrl_load) ctrl_q <= mem_rdata;
        end
    end

    rxd_status_fmt #(.SIZE_W(SIZE_W)) u_fmt (
        .ctrl_word  (ctrl_q),
        .frame      (finfo),
        .status_word(mem_wdata)
    );

    assign mem_addr   = ptr + ADDR_W'(word_sel);
    assign proc_state = state;

    // R2
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (base_we && state != ST_STOP) |=> $stable(base));

    // R6
    handback_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (!mem_wdata[OWN_BIT] && mem_wdata[LAST_BIT]));

    // R3
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_en && state == ST_STOP) |=> (!mem_req && !frm_ready));

endmodule

// File: tb/rxd_ring_engine_tb.sv
module rxd_ring_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            run_en = 1'b0;
    logic            base_we = 1'b0;
    logic [AW-1:0]   base_addr = '0;
    logic            frm_valid = 1'b0;
    logic [15:0]     frm_len = '0;
    logic            frm_err = 1'b0;
    logic            frm_ready, buf_unavail, mem_req, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [31:0]     mem_wdata;
    logic [31:0]     mem_rdata = '0;
    logic            mem_ack = 1'b0;
    logic [2:0]      proc_state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem [0:63];
    int lat = 0;
    int wcnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int last_wr_addr = -1;
    logic [31:0] last_wr_data = '0;
    int mptr = 0;
    int mbase = 0;
    logic prev_ready = 1'b0;

    rxd_ring_engine #(.ADDR_W(AW), .SIZE_W(11)) u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .base_we(base_we), .base_addr(base_addr),
        .frm_valid(frm_valid), .frm_len(frm_len), .frm_err(frm_err),
        .frm_ready(frm_ready), .buf_unavail(buf_unavail),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .proc_state(proc_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Memory model and per-cycle comparison against the reference ring position.
    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                wcnt = 0;
                mem_ack = 1'b1;
                // R9: only status (ptr) or control (ptr+1, read) words are touched
                chk((int'(mem_addr) == mptr) || (int'(mem_addr) == mptr + 1 && !mem_we),
                    "R9", "access address", mem_addr, mptr);
                if (mem_we) begin
                    mem[mem_addr[5:0]] = mem_wdata;
                    wr_cnt++;
                    last_wr_addr = int'(mem_addr);
                    last_wr_data = mem_wdata;
                end else begin
                    mem_rdata = mem[mem_addr[5:0]];
                    rd_cnt++;
                end
            end else begin
                wcnt++;
            end
        end
        if (!rst) begin
            // R10: single-cycle pulse
            if (frm_ready && prev_ready) chk(1'b0, "R10", "frm_ready width", 2, 1);
            // R3: a stopped engine stays quiet
            if (proc_state == 3'd0 && (mem_req || frm_ready))
                chk(1'b0, "R3", "activity while stopped", {mem_req, frm_ready}, 0);
        end
        prev_ready = frm_ready;
    end

    initial begin
        while (cycles < 20000) @(negedge clk);
        chk(1'b0, "watchdog", "cycle limit", cycles, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [31:0] exp_status(input int len, input bit err, input logic [31:0] ctrl);
        int size;
        int l;
        bit e;
        size = int'(ctrl & 32'h7FF);
        l = (len > size) ? size : len;
        e = err || (len > size);
        return (32'(l) << 16) | (e ? 32'h8000 : 32'h0) | 32'h100;
    endfunction

    task automatic set_desc(input int a, input bit own, input int size, input bit eor);
        mem[a]   = own ? 32'h8000_0000 : 32'h0;
        mem[a+1] = 32'(size) | (eor ? 32'h0200_0000 : 32'h0);
        mem[a+2] = 32'hB000_0000 | 32'(a);
        mem[a+3] = 32'hD000_0000 | 32'(a);
    endtask

    // Announces one frame, waits for completion and checks the outcome.
    task automatic run_frame(input int len, input bit err, input string req);
        bit owned;
        logic [31:0] ctrl;
        int rd0, wr0;
        bit ua;
        owned = mem[mptr][31];
        ctrl = mem[mptr+1];
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        @(negedge clk);
        frm_valid = 1'b1;
        frm_len = 16'(len);
        frm_err = err;
        do @(negedge clk); while (!frm_ready);
        ua = buf_unavail;
        frm_valid = 1'b0;
        if (owned) begin
            chk(!ua, "R4", "buf_unavail on owned descriptor", ua, 0);
            chk(wr_cnt == wr0 + 1 && rd_cnt == rd0 + 2, "R9", "accesses per frame",
                (wr_cnt - wr0) * 16 + (rd_cnt - rd0), 18);
            chk(last_wr_addr == mptr, "R6", "write-back address", last_wr_addr, mptr);
            chk(last_wr_data == exp_status(len, err, ctrl), req, "status word",
                last_wr_data, exp_status(len, err, ctrl));
            mptr = ctrl[25] ? mbase : mptr + 4;
        end else begin
            chk(ua, "R5", "buf_unavail on software descriptor", ua, 1);
            chk(wr_cnt == wr0 && rd_cnt == rd0 + 1, "R5", "accesses on drop",
                (wr_cnt - wr0) * 16 + (rd_cnt - rd0), 1);
        end
    endtask

    task automatic load_base(input int a);
        @(negedge clk);
        base_we = 1'b1;
        base_addr = AW'(a);
        @(negedge clk);
        base_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1
        chk(proc_state == 3'd0, "R1", "proc_state in reset", proc_state, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(proc_state == 3'd0 && !mem_req && !frm_ready && !buf_unavail,
            "R1", "idle outputs after reset", {proc_state, mem_req, frm_ready, buf_unavail}, 0);

        // Ring of three at word 8
        set_desc(8, 1, 100, 0);
        set_desc(12, 1, 64, 0);
        set_desc(16, 1, 1518, 1);
        load_base(8);   // R2 while stopped
        mbase = 8; mptr = 8;
        run_en = 1'b1;

        lat = 0; run_frame(60, 0, "R6");
        lat = 2; run_frame(64, 1, "R7");     // length equal to size: not cut, error kept
        lat = 1; run_frame(2000, 0, "R7");   // cut to 1518, error set
        chk(mptr == 8, "R8", "model wrapped", mptr, 8);
        lat = 0; run_frame(90, 0, "R5");     // descriptor 8 now owned by software
        chk(mptr == 8, "R5", "pointer held", mptr, 8);

        // R2: base load while running is ignored
        load_base(40);
        mem[8] = 32'h8000_0000;
        mem[12] = 32'h8000_0000;
        run_frame(65, 0, "R2");              // must land at 8
        run_frame(65, 0, "R7");              // 64-byte buffer: cut by one
        chk(mptr == 16, "R8", "model step", mptr, 16);

        // R3: stop, hold a frame, restart at the current pointer
        @(negedge clk);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(proc_state == 3'd0, "R3", "stopped state", proc_state, 0);
        mem[16] = 32'h8000_0000;
        begin
            int wr0;
            wr0 = wr_cnt;
            frm_valid = 1'b1; frm_len = 16'd200; frm_err = 1'b0;
            repeat (8) begin
                @(negedge clk);
                chk(!frm_ready && !mem_req, "R3", "held frame ignored while stopped",
                    {frm_ready, mem_req}, 0);
            end
            frm_valid = 1'b0;
            chk(wr_cnt == wr0, "R3", "no write while stopped", wr_cnt - wr0, 0);
        end
        run_en = 1'b1;
        run_frame(200, 1, "R3");             // resumes at 16, then wraps to 8
        chk(mptr == 8, "R8", "wrap after restart", mptr, 8);

        // New ring at 32 loaded while stopped
        @(negedge clk);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        set_desc(32, 1, 200, 0);
        set_desc(36, 1, 200, 1);
        load_base(32);
        mbase = 32; mptr = 32;
        run_en = 1'b1;
        lat = 1;
        run_frame(128, 0, "R2");
        run_frame(201, 0, "R7");
        chk(mptr == 32, "R8", "two-entry wrap", mptr, 32);
        run_frame(64, 0, "R5");              // 32 returned to software
        mem[32] = 32'h8000_0000;
        run_frame(64, 0, "R4");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule